// File: doc/BRIEF.md
# Preloadable Timer / Event Counter

This block is an up-counter with a reload value and a small control register. It is programmed over a simple register bus. The counter can count three kinds of input:

- rising edges on an external input pin;
- ticks of an internal clock made by dividing the block clock;
- internal ticks, but only while the external input is high, which measures the width of a pulse.

When the count passes its all-ones value, the counter loads the reload value again. On the same clock edge it raises a one-cycle overflow pulse, which a wake-up controller can use. It also sets a sticky flag. The flag, gated by an interrupt-enable bit, drives the interrupt request.

The same RTL serves both a narrow (8-bit) and a wide (16-bit) instance through the `CNT_W` parameter. The external input can be a pin that is shared with a general-purpose port, because the block treats it as fully asynchronous. Software writes the reload value at bus address 0 and reads the live count at the same address. Address 1 holds the control fields.

Top module: `tmr_evc`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, every control field (mode, run, interrupt enable, flag) is 0, and `irq` and `ovf_pulse` are low.
- R2: The control word at address 1 has these fields: mode in bits [1:0], run in bit 2, interrupt enable in bit 3 and flag in bit 4. Mode 00 is idle, 01 is event counting, 10 is internal-clock timing and 11 is pulse-width measurement. A read of address 1 returns these five bits, zero-extended.
- R3: A write to address 0 sets the reload register. A read of address 0 returns the live count.
- R4: A write to address 0 while run is 0 also loads the written value into the counter, visible after the write edge. While run is 1, the same write leaves the count unchanged.
- R5: The count holds its value when run is 0 or when the mode is 00.
- R6: In timer mode the count advances by one every `DIV` clock cycles (4 by default).
- R7: In event mode the count advances by one for each rising edge of `evt_in`. The edge passes through a two-flop synchronizer and an edge detector, so the increment appears at the third rising clock edge after `evt_in` rises.
- R8: In pulse-width mode the count advances on internal ticks only while the synchronized input is high. The synchronized falling edge clears run, unless software writes the control word in that same cycle.
- R9: An increment from all ones loads the reload value instead. In the same edge, `ovf_pulse` goes high for exactly one cycle and the flag is set.
- R10: `irq` is high exactly when the flag and the interrupt enable are both 1. Clearing the enable masks the request in every mode.
- R11: A control write with bit 4 at 0 clears the flag, and a control write with bit 4 at 1 leaves it as it was. An overflow in the same cycle as such a write sets the flag anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 = reload/count, 1 = control |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the selected register (combinational) |
| evt_in | input | 1 | Asynchronous external event / gate input |
| ovf_pulse | output | 1 | One-cycle pulse after each overflow (wake-up source) |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
A corrupted count shows up at the read port in the very next cycle, because address 0 is a combinational view of the counter. The bench compares that view with a lockstep model every cycle. A wrong prescaler phase or a wrong synchronizer depth moves the first increment by one or more cycles. The event-latency and tick-spacing checks catch this within one tick period. A flag or run bit in the wrong state shows on `irq` or in the control readback in the cycle after the offending edge.

// File: rtl/tmr_evc_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding and control-word bit positions for the timer.
package tmr_evc_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_EVT  = 2'b01,
        MODE_TMR  = 2'b10,
        MODE_PWM  = 2'b11
    } tmr_mode_e;

    localparam int CTL_MODE_LO = 0;
    localparam int CTL_RUN     = 2;
    localparam int CTL_IE      = 3;
    localparam int CTL_FLAG    = 4;
    localparam int CTL_W       = 5;

endpackage

// File: rtl/tmr_presc.sv
`timescale 1ns/1ps
// Module: tmr_presc
// Makes a one-cycle tick every DIV clocks, which serves as the internal count clock.
// Assumes DIV >= 1. The phase counter starts at zero on reset, so the first tick
// arrives in the DIV-th cycle after reset is released.
module tmr_presc #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] phase;

    assign tick = (phase == PW'(DIV - 1));

    // Free-running phase counter that wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else if (tick) phase <= '0;
        else phase <= phase + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R6: two ticks are never adjacent when the divider is above one
            a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tmr_insync.sv
`timescale 1ns/1ps
// Module: tmr_insync
// Brings the asynchronous external input into the clock domain through two flops,
// then compares it with a third flop to give one-cycle rise and fall strobes.
// Assumes the pin is held stable for at least two clocks per level.
module tmr_insync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic meta, sync, prev;

    // Synchronizer chain plus history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            sync <= 1'b0;
            prev <= 1'b0;
        end else begin
            meta <= pin;
            sync <= meta;
            prev <= sync;
        end
    end

    assign lvl  = sync;
    assign rise = sync & ~prev;
    assign fall = ~sync & prev;

    // R7: a detected rise reflects a pin value taken two edges earlier
    a_r7_rise_origin: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(pin, 2));
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
// Module: tmr_regs
// Holds the reload value and the control fields: mode, run, interrupt enable and
// the sticky overflow flag. A software write to the control word has priority over
// the hardware stop request. An overflow sets the flag even if a write clears it
// in the same cycle.
module tmr_regs
    import tmr_evc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pre,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] pre_wd,
    input  logic [CTL_W-1:0] ctl_wd,
    input  logic             ovf_set,
    input  logic             hw_stop,
    output logic [CNT_W-1:0] pre,
    output tmr_mode_e        mode,
    output logic             run,
    output logic             ie,
    output logic             flag
);
    // Reload register: written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) pre <= '0;
        else if (wr_pre) pre <= pre_wd;
    end

    // Mode, run and enable: a software write wins over the pulse-end stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_IDLE;
            run  <= 1'b0;
            ie   <= 1'b0;
        end else if (wr_ctl) begin
            mode <= tmr_mode_e'(ctl_wd[CTL_MODE_LO +: 2]);
            run  <= ctl_wd[CTL_RUN];
            ie   <= ctl_wd[CTL_IE];
        end else if (hw_stop) begin
            run  <= 1'b0;
        end
    end

    // Sticky flag: a write of 0 clears it, and an overflow sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else flag <= ovf_set | (wr_ctl ? (flag & ctl_wd[CTL_FLAG]) : flag);
    end

    // R8: the pulse-end stop clears run when no control write competes
    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stop && !wr_ctl) |=> !run);
    // R11: an overflow always leaves the flag set
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flag);
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
// Module: tmr_count
// The counter itself. It takes a direct load while stopped, or an increment that
// reloads from the preload value when the count is all ones. It flags the wrap both
// combinationally (for the flag) and as a registered one-cycle pulse.
// Assumes ld and inc are never high together (ld only while stopped).
module tmr_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] pre,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             ovf_q
);
    assign wrap = inc & (&cnt);

    // Count register: direct load, reload on wrap, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (ld) cnt <= ld_val;
        else if (wrap) cnt <= pre;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // Registered overflow strobe for wake-up logic.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else ovf_q <= wrap;
    end

    // R4: a load while stopped lands in the counter
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));
    // R5: without load or increment the count holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !inc) |=> $stable(cnt));
    // R6: a non-wrapping increment adds exactly one
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wrap && !ld) |=> (cnt == $past(cnt) + 1'b1));
    // R9: a wrap reloads and pulses
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ((cnt == $past(pre)) && ovf_q));
endmodule

// File: rtl/tmr_evc.sv
`timescale 1ns/1ps
// Module: tmr_evc (top)
// Timer / event counter with preload. The bus has two registers: address 0 holds
// the reload value on write and the live count on read, and address 1 holds the
// control word. The mode picks the count source: external edges, prescaled internal
// ticks, or internal ticks gated by the external level.
// Assumes CNT_W >= 5 (the control word fits the data bus) and evt_in is asynchronous.
module tmr_evc
    import tmr_evc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             evt_in,
    output logic             ovf_pulse,
    output logic             irq
);
    localparam int PAD_W = CNT_W - CTL_W;

    logic             tick, lvl, rise, fall;
    logic             wr_pre, wr_ctl, inc, ld, hw_stop, wrap;
    logic [CNT_W-1:0] pre, cnt;
    tmr_mode_e        mode;
    logic             run, ie, flag;
    logic [CTL_W-1:0] ctl_word;

    tmr_presc #(.DIV(DIV)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tmr_insync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (evt_in),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign wr_pre = bus_wr & ~bus_addr;
    assign wr_ctl = bus_wr &  bus_addr;
    assign ld     = wr_pre & ~run;

    // Count-source selection by mode; nothing counts while stopped or idle.
    always_comb begin
        inc = 1'b0;
        if (run) begin
            unique case (mode)
                MODE_EVT: inc = rise;
                MODE_TMR: inc = tick;
                MODE_PWM: inc = tick & lvl;
                default:  inc = 1'b0;
            endcase
        end
    end

    assign hw_stop = run & (mode == MODE_PWM) & fall;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_pre (wr_pre),
        .wr_ctl (wr_ctl),
        .pre_wd (bus_wdata),
        .ctl_wd (bus_wdata[CTL_W-1:0]),
        .ovf_set(wrap),
        .hw_stop(hw_stop),
        .pre    (pre),
        .mode   (mode),
        .run    (run),
        .ie     (ie),
        .flag   (flag)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .ld    (ld),
        .ld_val(bus_wdata),
        .pre   (pre),
        .cnt   (cnt),
        .wrap  (wrap),
        .ovf_q (ovf_pulse)
    );

    assign ctl_word  = {flag, ie, run, mode};
    assign bus_rdata = bus_addr ? {{PAD_W{1'b0}}, ctl_word} : cnt;
    assign irq       = flag & ie;

    // R9: every overflow pulse coincides with a set flag
    a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> flag);
    // R5: while stopped and not being written, the count does not move
    a_r5_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(cnt));
endmodule

// File: tb/tmr_evc_tb.sv
`timescale 1ns/1ps
// Bench for tmr_evc: directed corner cases, then seeded random traffic, with a
// lockstep reference model built from the requirements.
module tmr_evc_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_addr = 1'b0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         evt_in = 1'b0;
    logic         ovf_pulse, irq;

    int checks = 0;
    int errors = 0;
    bit lock_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tmr_evc #(.CNT_W(W), .DIV(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .ovf_pulse(ovf_pulse), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b01:   return "R7";
            2'b10:   return "R6";
            2'b11:   return "R8";
            default: return "R5";
        endcase
    endfunction

    // Reference model, derived from R1..R11
    logic [W-1:0] m_cnt, m_pre;
    logic [1:0]   m_mode, m_pc;
    logic         m_run, m_ie, m_flag, m_ovf, m_s1, m_s2, m_s3;

    always @(posedge clk) begin
        logic tk, inc, wrp, wp, wc;
        tk  = (m_pc == 2'd3);
        wp  = bus_wr && !bus_addr;
        wc  = bus_wr && bus_addr;
        inc = m_run && ((m_mode == 2'b01 && m_s2 && !m_s3) ||
                        (m_mode == 2'b10 && tk) ||
                        (m_mode == 2'b11 && tk && m_s2));
        wrp = inc && (m_cnt == 8'hFF);
        if (!rst_n) begin
            m_cnt <= '0; m_pre <= '0; m_mode <= '0; m_pc <= '0;
            m_run <= 0; m_ie <= 0; m_flag <= 0; m_ovf <= 0;
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
        end else begin
            m_s1 <= evt_in; m_s2 <= m_s1; m_s3 <= m_s2;
            m_pc <= tk ? 2'd0 : m_pc + 2'd1;
            if (wp) m_pre <= bus_wdata;
            if (wp && !m_run) m_cnt <= bus_wdata;
            else if (wrp) m_cnt <= m_pre;
            else if (inc) m_cnt <= m_cnt + 8'd1;
            if (wc) begin
                m_mode <= bus_wdata[1:0]; m_run <= bus_wdata[2]; m_ie <= bus_wdata[3];
            end else if (m_run && m_mode == 2'b11 && !m_s2 && m_s3) begin
                m_run <= 1'b0;
            end
            m_flag <= wrp | (wc ? (m_flag & bus_wdata[4]) : m_flag);
            m_ovf  <= wrp;
        end
    end

    // Lockstep comparison, sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (lock_on && rst_n) begin
            if (bus_addr)
                chk("R2 ctrl readback", bus_rdata, {3'b0, m_flag, m_ie, m_run, m_mode});
            else
                chk({mode_tag(m_mode), " count"}, bus_rdata, m_cnt);
            chk("R10 irq", irq, m_flag & m_ie);
            chk("R9 ovf_pulse", ovf_pulse, m_ovf);
        end
    end

    task automatic wr(input logic a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic sample();
        @(posedge clk); #1;
    endtask

    task automatic read_ctl(input string req, input logic [W-1:0] exp);
        @(negedge clk); bus_addr = 1'b1;
        sample();
        chk(req, bus_rdata, exp);
        @(negedge clk); bus_addr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] c0, c1;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        lock_on = 1'b1;

        // R1 reset state
        sample();
        chk("R1 count after reset", bus_rdata, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 ovf after reset", ovf_pulse, 0);
        read_ctl("R1 control after reset", 8'h00);

        // R3/R4 preload write while stopped loads counter
        wr(1'b0, 8'hA5);
        sample();
        chk("R4 load while stopped", bus_rdata, 8'hA5);
        chk("R3 read returns count", bus_rdata, 8'hA5);

        // R5 idle mode with run set: no counting; R2 readback
        wr(1'b1, 8'h04);
        repeat (20) sample();
        chk("R5 idle mode holds", bus_rdata, 8'hA5);
        read_ctl("R2 ctrl run bit", 8'h04);

        // R4 write while running changes only the preload
        wr(1'b0, 8'h10);
        sample();
        chk("R4 write while running keeps count", bus_rdata, 8'hA5);

        // R6 timer mode spacing
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hF0);
        wr(1'b1, 8'h0E);
        sample();
        c0 = bus_rdata;
        repeat (8) @(posedge clk);
        #1;
        c1 = bus_rdata;
        chk("R6 two ticks per eight cycles", c1 - c0, 2);

        // R9 overflow reloads and pulses; R10 irq
        for (int i = 0; i < 2000; i++) begin
            sample();
            if (ovf_pulse) break;
        end
        chk("R9 pulse seen", ovf_pulse, 1);
        chk("R9 reload value", bus_rdata, 8'hF0);
        chk("R10 irq raised", irq, 1);
        sample();
        chk("R9 pulse one cycle", ovf_pulse, 0);

        // R10 mask, R11 flag keep/clear
        wr(1'b1, 8'h16);
        sample();
        chk("R10 masked irq", irq, 0);
        read_ctl("R11 flag kept by write of 1", 8'h16);
        wr(1'b1, 8'h06);
        read_ctl("R11 flag cleared by write of 0", 8'h06);
        wr(1'b1, 8'h00);

        // R7 event mode latency and count
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h05);
        @(negedge clk); evt_in = 1'b1;
        sample(); chk("R7 no change after first edge", bus_rdata, 0);
        sample(); chk("R7 no change after second edge", bus_rdata, 0);
        sample(); chk("R7 increment at third edge", bus_rdata, 1);
        repeat (3) @(negedge clk);
        evt_in = 1'b0;
        for (int p = 0; p < 4; p++) begin
            repeat (3) @(negedge clk); evt_in = 1'b1;
            repeat (3) @(negedge clk); evt_in = 1'b0;
        end
        repeat (6) sample();
        chk("R7 five events counted", bus_rdata, 5);

        // R8 pulse-width measurement and auto stop
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h07);
        @(negedge clk); evt_in = 1'b1;
        repeat (40) @(negedge clk);
        evt_in = 1'b0;
        repeat (10) sample();
        c0 = bus_rdata;
        chk("R8 width count in range", (c0 >= 9 && c0 <= 11), 1);
        read_ctl("R8 run cleared at trailing edge", 8'h03);
        repeat (12) sample();
        chk("R5 stopped after pulse", bus_rdata, c0);

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = 1'b0;
            if (($urandom % 6) == 0) evt_in = ~evt_in;
            r = $urandom % 24;
            if (r == 0) begin
                bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'hE0 | 8'($urandom % 32);
            end else if (r == 1) begin
                bus_wr = 1'b1; bus_addr = 1'b1;
                bus_wdata = {3'b0, 1'($urandom), 1'($urandom), 1'b1, 2'($urandom)};
            end else if (r == 2) begin
                bus_addr = 1'b1;
            end
        end
        @(negedge clk); bus_wr = 1'b0; bus_addr = 1'b0;
        repeat (4) sample();
        finish_run();
    end
endmodule